// File: doc/BRIEF.md
# Program Memory Region Decoder

This block sits between the instruction fetch and table-access path of a small processor and its program memory. For every access it takes a 21-bit byte address and a 2-bit operating-mode selector and decides whether the access is served by on-chip flash, by an external parallel memory bus, or by neither. When neither serves it, the access reads as all zeros. Two address limits, the top of the boot block and the top of on-chip memory, are parameters.

It also decides what the shared external pins do. During an external access they act as bus pins and carry the control word produced by the bus-cycle timer. During internal execution they either park in a defined idle state or are handed over to general-purpose I/O, as chosen by a bus-disable control bit. In internal-only mode the pins are always I/O. The decode outputs are combinational. The pin mode and the pin control word are registered, so they follow the access by one clock.

The block has no data stream and so no valid/ready handshake. `acc_valid` marks a cycle that carries an access and is never back-pressured. All other controls are plain level signals.

Top module: `prog_region_decoder`

## Requirements
- R1: With `op_mode` = 2'b00, a valid access at an address at or below ONCHIP_TOP (default 00FFFFh) sets `int_sel`. A valid access above it sets `ext_req`.
- R2: With `op_mode` = 2'b11, a valid access at or below ONCHIP_TOP sets `int_sel`. A valid access above it sets `read_zero`, and neither `ext_req` nor `int_sel` is set.
- R3: With `op_mode` = 2'b10, every valid access sets `ext_req`, whatever its address, and `int_sel` stays low.
- R4: With `op_mode` = 2'b01, a valid access at or below BOOT_TOP (default 0007FFh) sets `int_sel`. Any address above it, up to 1FFFFFh, sets `ext_req`.
- R5: `ce_n` (active low) is 0 exactly when `ext_req` is 1. With `acc_valid` = 0, the outputs `ext_req`, `int_sel` and `read_zero` are all 0 and `ce_n` is 1.
- R6: In modes 00, 01 and 10, during a cycle with no external access, `pin_mode` on the next clock is 2'b01 (parked: address/data pins tri-stated) when `bus_off` = 0, and 2'b00 (port I/O) when `bus_off` = 1.
- R7: `bus_off` has no effect during an external access: `pin_mode` on the next clock is 2'b10 (bus). `bus_off` also has no effect in mode 11: `pin_mode` on the next clock is 2'b00.
- R8: `pin_ctl` has bit order {oe_n, wrh_n, wrl_n, ub_n, lb_n, ale, ba0}. When `pin_mode` is 2'b10 it equals `cyc_ctl` from the previous cycle. Otherwise it equals 7'b1111100: the strobes and byte enables are high, and ALE and the byte-address line are low.
- R9: While `rst_n` is low, `pin_mode` is 2'b00 and `pin_ctl` is 7'b1111100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_mode | input | 2 | Operating-mode selector (00, 01, 10, 11 as in R1–R4) |
| acc_valid | input | 1 | The current cycle carries a program-memory access |
| acc_addr | input | 21 | Byte address of the access |
| bus_off | input | 1 | Bus-disable bit: 1 hands the pins to port I/O while execution is internal |
| cyc_ctl | input | 7 | Control levels from the bus-cycle timer, in R8 bit order |
| ext_req | output | 1 | Request an external bus cycle |
| int_sel | output | 1 | Access served by on-chip memory |
| read_zero | output | 1 | Access returns all zeros |
| ce_n | output | 1 | External chip enable, active low |
| pin_mode | output | 2 | Registered pin function: 00 port I/O, 01 parked, 10 bus |
| pin_ctl | output | 7 | Registered control pin levels, R8 bit order |

## Verification
The hard cases are the exact boundary addresses in each mode. The sharpest is the boot limit, where address BOOT_TOP is internal and BOOT_TOP+1 is external. The other is `bus_off` being toggled while an external access is in progress, or while mode 11 is selected, where the bit must change nothing. The stimulus first walks every mode across a fixed set of addresses: 0, each limit, each limit plus one, and 1FFFFFh. Each of these is driven with both values of `bus_off` and of `acc_valid`. A long pseudo-random phase then mixes the four modes with addresses drawn near the limits, so that mode changes land in the middle of runs of external and internal accesses.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT    = 2'b00,
    MODE_BOOT     = 2'b01,
    MODE_EXT_ONLY = 2'b10,
    MODE_INT_ONLY = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    PM_PORT = 2'b00,
    PM_PARK = 2'b01,
    PM_BUS  = 2'b10
  } pin_mode_e;

  localparam int unsigned CTL_W = 7;
  // {oe_n, wrh_n, wrl_n, ub_n, lb_n, ale, ba0}
  localparam logic [CTL_W-1:0] CTL_PARK = 7'b1111100;
endpackage

// File: rtl/prd_region_map.sv
module prd_region_map
  import prd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 21,
  parameter int unsigned BOOT_TOP   = 32'h0007FF,
  parameter int unsigned ONCHIP_TOP = 32'h00FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              ext_req,
  output logic              int_sel,
  output logic              read_zero
);
  localparam logic [ADDR_W-1:0] BOOT_LIM = BOOT_TOP[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CHIP_LIM = ONCHIP_TOP[ADDR_W-1:0];
  localparam int unsigned NMODE = 4;

  logic in_boot, in_chip;
  logic [NMODE-1:0] ext_by_mode, int_by_mode, zero_by_mode;

  assign in_boot = (acc_addr <= BOOT_LIM);
  assign in_chip = (acc_addr <= CHIP_LIM);

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    if (m == int'(MODE_SPLIT)) begin : g_split
      assign int_by_mode[m]  = in_chip;
      assign ext_by_mode[m]  = !in_chip;
      assign zero_by_mode[m] = 1'b0;
    end else if (m == int'(MODE_BOOT)) begin : g_boot
      assign int_by_mode[m]  = in_boot;
      assign ext_by_mode[m]  = !in_boot;
      assign zero_by_mode[m] = 1'b0;
    end else if (m == int'(MODE_EXT_ONLY)) begin : g_ext
      assign int_by_mode[m]  = 1'b0;
      assign ext_by_mode[m]  = 1'b1;
      assign zero_by_mode[m] = 1'b0;
    end else begin : g_int
      assign int_by_mode[m]  = in_chip;
      assign ext_by_mode[m]  = 1'b0;
      assign zero_by_mode[m] = !in_chip;
    end
  end

  always_comb begin
    ext_req   = acc_valid & ext_by_mode[op_mode];
    int_sel   = acc_valid & int_by_mode[op_mode];
    read_zero = acc_valid & zero_by_mode[op_mode];
  end

  // R2: a zero read never starts an external cycle
  a_r2_zero_no_ext : assert property (@(posedge clk) disable iff (!rst_n)
    read_zero |-> !ext_req && !int_sel);
  // R3: external-only mode sends every valid access out
  a_r3_ext_only : assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && op_mode == MODE_EXT_ONLY) |-> ext_req && !int_sel);
  // R4: boot split at the boot limit
  a_r4_boot_split : assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && op_mode == MODE_BOOT) |-> (ext_req == (acc_addr > BOOT_LIM)));
  // R5: nothing is selected without an access
  a_r5_idle : assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !ext_req && !int_sel && !read_zero);
  // R1: exactly one outcome per valid access
  a_r1_one_outcome : assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones({ext_req, int_sel, read_zero}) == 1);
endmodule

// File: rtl/prd_pin_ctrl.sv
module prd_pin_ctrl
  import prd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_only,
  input  logic             ext_act,
  input  logic             bus_off,
  input  logic [CTL_W-1:0] cyc_ctl,
  output logic [1:0]       pin_mode,
  output logic [CTL_W-1:0] pin_ctl
);
  pin_mode_e        mode_d, mode_q;
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    if (int_only)     mode_d = PM_PORT;
    else if (ext_act) mode_d = PM_BUS;
    else if (bus_off) mode_d = PM_PORT;
    else              mode_d = PM_PARK;
    ctl_d = (mode_d == PM_BUS) ? cyc_ctl : CTL_PARK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_PORT;
      pin_ctl <= CTL_PARK;
    end else begin
      mode_q  <= mode_d;
      pin_ctl <= ctl_d;
    end
  end

  assign pin_mode = mode_q;

  // R7: an external access always takes the pins as bus pins
  a_r7_ext_bus : assert property (@(posedge clk) disable iff (!rst_n)
    ext_act |=> pin_mode == PM_BUS);
  // R7: internal-only mode never drives the bus
  a_r7_int_only_port : assert property (@(posedge clk) disable iff (!rst_n)
    int_only |=> pin_mode == PM_PORT);
  // R8: idle levels whenever the bus is not active
  a_r8_park_levels : assert property (@(posedge clk) disable iff (!rst_n)
    pin_mode != PM_BUS |-> pin_ctl == CTL_PARK);
  // R6: internal execution with the bus enabled parks the pins
  a_r6_park : assert property (@(posedge clk) disable iff (!rst_n)
    (!int_only && !ext_act && !bus_off) |=> pin_mode == PM_PARK);
endmodule

// File: rtl/prog_region_decoder.sv
module prog_region_decoder
  import prd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 21,
  parameter int unsigned BOOT_TOP   = 32'h0007FF,
  parameter int unsigned ONCHIP_TOP = 32'h00FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              bus_off,
  input  logic [6:0]        cyc_ctl,
  output logic              ext_req,
  output logic              int_sel,
  output logic              read_zero,
  output logic              ce_n,
  output logic [1:0]        pin_mode,
  output logic [6:0]        pin_ctl
);
  logic int_only;

  prd_region_map #(
    .ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP), .ONCHIP_TOP(ONCHIP_TOP)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .ext_req(ext_req), .int_sel(int_sel),
    .read_zero(read_zero)
  );

  assign int_only = (op_mode == MODE_INT_ONLY);
  assign ce_n     = !ext_req;

  prd_pin_ctrl u_pins (
    .clk(clk), .rst_n(rst_n), .int_only(int_only), .ext_act(ext_req),
    .bus_off(bus_off), .cyc_ctl(cyc_ctl), .pin_mode(pin_mode),
    .pin_ctl(pin_ctl)
  );

  // R5: chip enable only for external-capable modes with a live access
  a_r5_ce_scope : assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> acc_valid && op_mode != MODE_INT_ONLY);
endmodule

// File: tb/test_prog_region_decoder.sv
module test_prog_region_decoder;
  localparam int BOOT = 'h0007FF;
  localparam int CHIP = 'h00FFFF;
  localparam int TOP  = 'h1FFFFF;
  localparam logic [6:0] PARK = 7'b1111100;

  logic clk = 0, rst_n = 0;
  logic [1:0] op_mode = 0;
  logic acc_valid = 0, bus_off = 0;
  logic [20:0] acc_addr = 0;
  logic [6:0] cyc_ctl = 0;
  logic ext_req, int_sel, read_zero, ce_n;
  logic [1:0] pin_mode;
  logic [6:0] pin_ctl;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [1:0] exp_pm;
  logic [6:0] exp_ctl;

  always #10 clk = ~clk;

  prog_region_decoder i_prog_region_decoder (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .bus_off(bus_off), .cyc_ctl(cyc_ctl),
    .ext_req(ext_req), .int_sel(int_sel), .read_zero(read_zero),
    .ce_n(ce_n), .pin_mode(pin_mode), .pin_ctl(pin_ctl)
  );

  // expected decode: 0 internal, 1 external, 2 zero read
  function automatic int route(input int m, input int a);
    case (m)
      0: return (a <= CHIP) ? 0 : 1;
      1: return (a <= BOOT) ? 0 : 1;
      2: return 1;
      default: return (a <= CHIP) ? 0 : 2;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (mode %0d addr %0h)",
               req, act, expv, op_mode, acc_addr);
    end
  endtask

  // reference state for registered outputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_pm  = 2'b00;
      exp_ctl = PARK;
    end else begin
      int r;
      r = route(int'(op_mode), int'(acc_addr));
      if (op_mode == 2'b11)          exp_pm = 2'b00;
      else if (acc_valid && r == 1)  exp_pm = 2'b10;
      else if (bus_off)              exp_pm = 2'b00;
      else                           exp_pm = 2'b01;
      exp_ctl = (exp_pm == 2'b10) ? cyc_ctl : PARK;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(pin_mode == 2'b00, "R9", pin_mode, 0);
        chk(pin_ctl == PARK, "R9", pin_ctl, PARK);
      end else begin
        int r;
        string rq;
        bit e, i, z;
        r = route(int'(op_mode), int'(acc_addr));
        e = acc_valid && r == 1;
        i = acc_valid && r == 0;
        z = acc_valid && r == 2;
        case (op_mode)
          2'b00: rq = "R1";
          2'b01: rq = "R4";
          2'b10: rq = "R3";
          default: rq = "R2";
        endcase
        if (!acc_valid) rq = "R5";
        chk(ext_req == e, rq, ext_req, e);
        chk(int_sel == i, rq, int_sel, i);
        chk(read_zero == z, rq, read_zero, z);
        chk(ce_n == !e, "R5", ce_n, !e);
        chk(pin_mode == exp_pm, (exp_pm == 2'b01 || op_mode == 2'b00) ? "R6" : "R7",
            pin_mode, exp_pm);
        chk(pin_ctl == exp_ctl, "R8", pin_ctl, exp_ctl);
      end
    end
  end

  task automatic drive(input int m, input int a, input bit v, input bit bo, input logic [6:0] c);
    @(negedge clk);
    #2;
    op_mode = m[1:0]; acc_addr = a[20:0]; acc_valid = v; bus_off = bo; cyc_ctl = c;
  endtask

  int corner[7];
  logic [31:0] lfsr = 32'h1ACE5EED;

  initial begin
    corner = '{0, BOOT, BOOT + 1, CHIP, CHIP + 1, TOP, 'h100000};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // directed corners: every mode, address, valid and bus_off value
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 7; k++)
        for (int v = 0; v < 2; v++)
          for (int b = 0; b < 2; b++)
            drive(m, corner[k], v[0], b[0], 7'(m * 29 + k * 5 + b));
    // bus_off toggles during a run of external accesses and in mode 11
    for (int j = 0; j < 8; j++) drive(2, j * 'h3000, 1, j[0], 7'h55 ^ 7'(j));
    for (int j = 0; j < 8; j++) drive(3, CHIP + j - 4, j[1], j[0], 7'h2A);
    // pseudo-random mixing near the limits
    for (int j = 0; j < 3000; j++) begin
      int a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[5:4])
        2'd0: a = BOOT - 2 + int'(lfsr[9:7]);
        2'd1: a = CHIP - 2 + int'(lfsr[9:7]);
        default: a = int'(lfsr[30:10]);
      endcase
      drive(int'(lfsr[1:0]), a, lfsr[2] | lfsr[3], lfsr[11], lfsr[18:12]);
    end
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule